// File: doc/BRIEF.md
# Cellular Automaton 3x3 Tile

The tile holds a 3x3 block of binary cells of a two-dimensional cellular automaton and advances all nine cells together. Every cell's next value depends on itself and on its eight surrounding cells. For cells on the block edge, some of those neighbours belong to adjacent tiles. They arrive as a 16-bit ring of cells that surrounds the block. The nine states are driven back out so that neighbouring tiles can use them. Tiles never overlap. They are joined edge to edge in rows and columns and all run on one common clock, so each enabled clock moves the whole array forward one generation or one sub-step.

A two-bit rule select picks one of four behaviours:

- A birth/survival rule in the style of Life.
- A nine-cell majority vote.
- A two-phase rule. Its first step parks an intermediate result in a per-cell phase register, and its second step applies it.
- An idle code that inserts a no-operation step.

A synchronous load port seeds the nine cells. The cell outputs come straight from registers.

Cell numbering: cell k sits at row k/3, column k%3, with row 0 on top and column 0 on the left. The tile is placed in a 5x5 padded grid, with cell (r,c) at grid position (r+1,c+1). Ring bit j is assigned as follows:

- Bits 0..4 are the top grid row, from left to right.
- Bits 5..7 are the right grid column, rows 1..3 from top to bottom.
- Bits 8..12 are the bottom grid row, from right to left.
- Bits 13..15 are the left grid column, rows 3..1 from bottom to top.

Top module: `ca_tile`

## Requirements
- R1: While `rst` is high at a clock edge, all cells and the phase flag clear. After reset the outputs read 0, and the next two-phase step behaves as a first phase.
- R2: When `load_en` is high at an edge, `cells_out` equals `load_cells` after that edge and the phase flag clears. This holds whatever `step_en` or `rule_sel` are in that cycle: load takes priority over a step.
- R3: With `load_en` and `step_en` both low, `cells_out` and the phase flag hold, whatever the ring and rule inputs do.
- R4: Ring bit j and cell bit k map to grid positions exactly as stated above. A cell's eight neighbours are its adjacent grid positions.
- R5: Rule code 2'b00 (Life): a dead cell becomes live with exactly 3 live neighbours. A live cell stays live with 2 or 3 live neighbours. Every other cell becomes dead. Any such step clears the phase flag.
- R6: Rule code 2'b01 (majority): a cell becomes live when at least 5 of the 9 cells (itself plus its eight neighbours) are live. Otherwise it becomes dead. Any such step clears the phase flag.
- R7: Rule code 2'b10 with the phase flag clear: each cell stores the XOR of its eight neighbours as an intermediate value, the cells hold, and the phase flag sets.
- R8: Rule code 2'b10 with the phase flag set: each cell becomes its current value XOR its stored intermediate value, and the phase flag clears.
- R9: Rule code 2'b11 (idle): a step changes neither the cells nor the phase flag. It may be inserted between the two phases of rule 2'b10.
- R10: Once the phase flag is cleared by a Life step, a majority step or a load, the following 2'b10 step is again a first phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common array clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the tile by one step |
| load_en | input | 1 | Write `load_cells` into the cells |
| load_cells | input | 9 | Initial cell states, bit k = cell k |
| rule_sel | input | 2 | Rule code: 00 Life, 01 majority, 10 two-phase, 11 idle |
| halo_in | input | 16 | Surrounding ring of neighbour cells from adjacent tiles |
| cells_out | output | 9 | Registered cell states, bit k = cell k |

## Verification
Load and step can be requested in the same cycle. The bench raises `load_en` and `step_en` together under the Life rule, with a pattern whose Life successor differs from the loaded value. It then expects the loaded value, not the successor. The second collision is between the two-phase sequence and the other rules. A first phase is followed by a load, a Life step or an idle step. The bench then judges whether the next two-phase step holds the cells (the phase was cleared) or applies the stored XOR (the phase was kept), using an independent grid model.

// File: rtl/ca_tile_pkg.sv
package ca_tile_pkg;

    typedef enum logic [1:0] {
        RULE_LIFE = 2'b00,
        RULE_MAJ  = 2'b01,
        RULE_TWO  = 2'b10,
        RULE_IDLE = 2'b11
    } rule_e;

    // Candidate next values produced for one cell
    typedef struct packed {
        logic life;
        logic maj;
        logic par;
    } cell_eval_t;

    // Ring position of a border point of the padded grid
    function automatic int halo_idx(int pr, int pc, int rows, int cols);
        int idx;
        if (pr == 0)
            idx = pc;
        else if (pr == rows + 1)
            idx = cols + 2 + rows + (cols + 1 - pc);
        else if (pc == cols + 1)
            idx = cols + 2 + (pr - 1);
        else
            idx = 2 * cols + 4 + rows + (rows - pr);
        return idx;
    endfunction

    function automatic logic [3:0] count8(logic [7:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++)
            n = n + {3'b000, v[i]};
        return n;
    endfunction

endpackage

// File: rtl/ca_halo_map.sv
module ca_halo_map #(
    parameter int ROWS = 3,
    parameter int COLS = 3,
    localparam int NC  = ROWS * COLS,
    localparam int HW  = 2 * (ROWS + COLS) + 4,
    localparam int GW  = COLS + 2,
    localparam int GN  = (ROWS + 2) * GW
) (
    input  logic [NC-1:0] cells,
    input  logic [HW-1:0] halo,
    output logic [GN-1:0] grid
);
    for (genvar pr = 0; pr < ROWS + 2; pr++) begin : g_row
        for (genvar pc = 0; pc < GW; pc++) begin : g_col
            if (pr >= 1 && pr <= ROWS && pc >= 1 && pc <= COLS) begin : g_in
                assign grid[pr*GW+pc] = cells[(pr-1)*COLS + (pc-1)];
            end else begin : g_ring
                localparam int HI = ca_tile_pkg::halo_idx(pr, pc, ROWS, COLS);
                assign grid[pr*GW+pc] = halo[HI];
            end
        end
    end
endmodule

// File: rtl/ca_cell_rule.sv
module ca_cell_rule
    import ca_tile_pkg::*;
(
    input  logic [7:0]  nbr,
    input  logic        self_q,
    output cell_eval_t  ev
);
    logic [3:0] n;
    logic [4:0] total;

    always_comb begin
        n        = count8(nbr);
        total    = {1'b0, n} + {4'b0000, self_q};
        ev.life  = (n == 4'd3) || (self_q && n == 4'd2);
        ev.maj   = (total >= 5'd5);
        ev.par   = ^nbr;
    end
endmodule

// File: rtl/ca_tile.sv
module ca_tile
    import ca_tile_pkg::*;
#(
    parameter int TILE_R = 3,
    parameter int TILE_C = 3,
    localparam int NC = TILE_R * TILE_C,
    localparam int HW = 2 * (TILE_R + TILE_C) + 4,
    localparam int GW = TILE_C + 2,
    localparam int GN = (TILE_R + 2) * GW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          load_en,
    input  logic [NC-1:0] load_cells,
    input  logic [1:0]    rule_sel,
    input  logic [HW-1:0] halo_in,
    output logic [NC-1:0] cells_out
);
    logic [NC-1:0] cells_q;
    logic [NC-1:0] mid_q;
    logic          phase_q;
    logic [GN-1:0] grid;
    cell_eval_t    ev [NC];
    logic [NC-1:0] life_v, maj_v, par_v;
    rule_e         rule;

    assign rule = rule_e'(rule_sel);

    ca_halo_map #(.ROWS(TILE_R), .COLS(TILE_C)) u_map (
        .cells (cells_q),
        .halo  (halo_in),
        .grid  (grid)
    );

    for (genvar r = 0; r < TILE_R; r++) begin : g_r
        for (genvar c = 0; c < TILE_C; c++) begin : g_c
            localparam int K  = r * TILE_C + c;
            localparam int UP = r * GW + c + 1;
            localparam int MD = (r + 1) * GW + c + 1;
            localparam int DN = (r + 2) * GW + c + 1;
            logic [7:0] nbr;
            assign nbr = {grid[UP-1], grid[UP], grid[UP+1],
                          grid[MD-1],           grid[MD+1],
                          grid[DN-1], grid[DN], grid[DN+1]};
            ca_cell_rule u_rule (
                .nbr    (nbr),
                .self_q (cells_q[K]),
                .ev     (ev[K])
            );
            assign life_v[K] = ev[K].life;
            assign maj_v[K]  = ev[K].maj;
            assign par_v[K]  = ev[K].par;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cells_q <= '0;
            mid_q   <= '0;
            phase_q <= 1'b0;
        end else if (load_en) begin
            cells_q <= load_cells;
            phase_q <= 1'b0;
        end else if (step_en) begin
            unique case (rule)
                RULE_LIFE: begin
                    cells_q <= life_v;
                    phase_q <= 1'b0;
                end
                RULE_MAJ: begin
                    cells_q <= maj_v;
                    phase_q <= 1'b0;
                end
                RULE_TWO: begin
                    if (!phase_q) begin
                        mid_q   <= par_v;
                        phase_q <= 1'b1;
                    end else begin
                        cells_q <= cells_q ^ mid_q;
                        phase_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cells_out = cells_q;
endmodule

// File: rtl/ca_tile_chk.sv
module ca_tile_chk #(
    parameter int NC = 9,
    parameter int HW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          step_en,
    input logic          load_en,
    input logic [NC-1:0] load_cells,
    input logic [1:0]    rule_sel,
    input logic [HW-1:0] halo_in,
    input logic [NC-1:0] cells_out,
    input logic          phase_q
);
    logic live_step;
    assign live_step = step_en && !load_en;

    a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cells_out == $past(load_cells)) && !phase_q);

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !step_en) |=> $stable(cells_out) && $stable(phase_q));

    a_r5_life_quiet: assert property (@(posedge clk) disable iff (rst)
        (live_step && rule_sel == 2'b00 && halo_in == '0 && cells_out == '0)
        |=> cells_out == '0);

    a_r7_first_phase: assert property (@(posedge clk) disable iff (rst)
        (live_step && rule_sel == 2'b10 && !phase_q)
        |=> phase_q && $stable(cells_out));

    a_r8_second_phase: assert property (@(posedge clk) disable iff (rst)
        (live_step && rule_sel == 2'b10 && phase_q) |=> !phase_q);

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (live_step && rule_sel == 2'b11)
        |=> $stable(cells_out) && $stable(phase_q));

    a_r10_phase_clear: assert property (@(posedge clk) disable iff (rst)
        (live_step && (rule_sel == 2'b00 || rule_sel == 2'b01)) |=> !phase_q);
endmodule

bind ca_tile ca_tile_chk #(.NC(NC), .HW(HW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .load_en    (load_en),
    .load_cells (load_cells),
    .rule_sel   (rule_sel),
    .halo_in    (halo_in),
    .cells_out  (cells_out),
    .phase_q    (phase_q)
);

// File: tb/ca_tile_tb.sv
module ca_tile_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        step_en;
    logic        load_en;
    logic [8:0]  load_cells;
    logic [1:0]  rule_sel;
    logic [15:0] halo_in;
    logic [8:0]  cells_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ca_tile u_dut (
        .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en),
        .load_cells(load_cells), .rule_sel(rule_sel),
        .halo_in(halo_in), .cells_out(cells_out)
    );

    // Independent model: mode 0 Life, 1 majority, 2 neighbour parity
    function automatic logic [8:0] model(int mode, logic [8:0] c, logic [15:0] h);
        logic g [5][5];
        logic [8:0] res;
        for (int j = 0; j < 5; j++) begin
            g[0][j] = h[j];
            g[4][j] = h[8 + (4 - j)];
        end
        for (int i = 1; i < 4; i++) begin
            g[i][4] = h[4 + i];
            g[i][0] = h[12 + (4 - i)];
            for (int j = 1; j < 4; j++) g[i][j] = c[(i-1)*3 + j - 1];
        end
        for (int k = 0; k < 9; k++) begin
            int r = k / 3 + 1;
            int q = k % 3 + 1;
            int cnt = 0;
            logic px = 1'b0;
            for (int dr = -1; dr <= 1; dr++)
                for (int dq = -1; dq <= 1; dq++)
                    if (dr != 0 || dq != 0) begin
                        cnt += int'(g[r+dr][q+dq]);
                        px ^= g[r+dr][q+dq];
                    end
            case (mode)
                0: res[k] = (cnt == 3) || (g[r][q] && cnt == 2);
                1: res[k] = (cnt + int'(g[r][q])) >= 5;
                default: res[k] = px;
            endcase
        end
        return res;
    endfunction

    task automatic chk(string req, logic [8:0] got, logic [8:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Apply one cycle of inputs at negedge; outputs settle by the next negedge
    task automatic cyc(logic st, logic ld, logic [8:0] lc, logic [1:0] rs, logic [15:0] h);
        step_en = st; load_en = ld; load_cells = lc; rule_sel = rs; halo_in = h;
        @(negedge clk);
        step_en = 1'b0; load_en = 1'b0;
    endtask

    task automatic do_load(logic [8:0] v);
        cyc(1'b0, 1'b1, v, 2'b11, 16'h0);
    endtask

    task automatic t_reset;
        rst = 1'b1; step_en = 0; load_en = 0; load_cells = 0; rule_sel = 0; halo_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset cells", cells_out, 9'h0);
    endtask

    task automatic t_load;
        do_load(9'b101100111);
        chk("R2 load", cells_out, 9'b101100111);
        // load and Life step together: successor of a blinker would differ
        cyc(1'b1, 1'b1, 9'b000111000, 2'b00, 16'h0);
        chk("R2 load over step", cells_out, 9'b000111000);
    endtask

    task automatic t_hold;
        cyc(1'b0, 1'b0, 9'h1ff, 2'b00, 16'hffff);
        chk("R3 hold life", cells_out, 9'b000111000);
        cyc(1'b0, 1'b0, 9'h000, 2'b10, 16'h5a5a);
        chk("R3 hold two", cells_out, 9'b000111000);
    endtask

    task automatic t_ring;
        do_load(9'h0);
        cyc(1'b1, 1'b0, 9'h0, 2'b00, 16'b0000_0000_0000_1110);
        chk("R4 top ring", cells_out, 9'b000000010);
        do_load(9'h0);
        cyc(1'b1, 1'b0, 9'h0, 2'b00, 16'b0000_0000_1110_0000);
        chk("R4 right ring", cells_out, 9'b000100000);
    endtask

    task automatic t_life;
        logic [8:0]  c = 9'h0a5;
        logic [15:0] h = 16'h3c91;
        do_load(9'b000111000);
        cyc(1'b1, 1'b0, 9'h0, 2'b00, 16'h0);
        chk("R5 blinker", cells_out, 9'b010010010);
        for (int i = 0; i < 6; i++) begin
            c = c * 9'd37 + 9'd11;
            h = h * 16'd25173 + 16'd13849;
            do_load(c);
            cyc(1'b1, 1'b0, 9'h0, 2'b00, h);
            chk("R5 life model", cells_out, model(0, c, h));
        end
    endtask

    task automatic t_maj;
        logic [8:0]  c = 9'h13b;
        logic [15:0] h = 16'h7e02;
        do_load(9'h1ff);
        cyc(1'b1, 1'b0, 9'h0, 2'b01, 16'h0);
        chk("R6 full block", cells_out, 9'b010111010);
        for (int i = 0; i < 6; i++) begin
            c = c * 9'd101 + 9'd7;
            h = h * 16'd31421 + 16'd6927;
            do_load(c);
            cyc(1'b1, 1'b0, 9'h0, 2'b01, h);
            chk("R6 majority model", cells_out, model(1, c, h));
        end
    endtask

    task automatic t_two;
        logic [8:0] c = 9'b110010011;
        logic [15:0] h = 16'hb4e1;
        logic [8:0] m = model(2, c, h);
        do_load(c);
        cyc(1'b1, 1'b0, 9'h0, 2'b10, h);
        chk("R7 first phase holds", cells_out, c);
        cyc(1'b1, 1'b0, 9'h0, 2'b10, 16'h0f0f);
        chk("R8 second phase", cells_out, c ^ m);
    endtask

    task automatic t_idle;
        logic [8:0] c = 9'b011101001;
        logic [15:0] h = 16'h91c3;
        logic [8:0] m = model(2, c, h);
        do_load(c);
        cyc(1'b1, 1'b0, 9'h0, 2'b10, h);
        cyc(1'b1, 1'b0, 9'h0, 2'b11, 16'hffff);
        chk("R9 idle holds", cells_out, c);
        cyc(1'b1, 1'b0, 9'h0, 2'b10, 16'h0);
        chk("R9 phase kept over idle", cells_out, c ^ m);
    endtask

    task automatic t_clear;
        logic [8:0] c;
        do_load(9'b000111000);
        cyc(1'b1, 1'b0, 9'h0, 2'b10, 16'hffff);
        cyc(1'b1, 1'b0, 9'h0, 2'b00, 16'h0);
        chk("R10 life after first phase", cells_out, 9'b010010010);
        c = cells_out;
        cyc(1'b1, 1'b0, 9'h0, 2'b10, 16'hffff);
        chk("R10 phase cleared by life", cells_out, c);
        cyc(1'b1, 1'b0, 9'h0, 2'b01, 16'h0);
        c = cells_out;
        cyc(1'b1, 1'b0, 9'h0, 2'b10, 16'h1234);
        chk("R10 phase cleared by majority", cells_out, c);
        do_load(9'b100000001);
        cyc(1'b1, 1'b0, 9'h0, 2'b10, 16'h8001);
        chk("R10 phase cleared by load", cells_out, 9'b100000001);
        // reset also clears a pending phase
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 reset after phase", cells_out, 9'h0);
        do_load(9'b010101010);
        cyc(1'b1, 1'b0, 9'h0, 2'b10, 16'hffff);
        chk("R1 first phase after reset", cells_out, 9'b010101010);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_load;
        t_hold;
        t_ring;
        t_life;
        t_maj;
        t_two;
        t_idle;
        t_clear;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule